// File: doc/BRIEF.md
# Encoded Interrupt Level Trap Unit

This block decides when a small RISC core must leave its instruction stream to service an external interrupt. Requests arrive as a 4-bit priority code. A code of zero means that nothing is requested. The code is synchronised, filtered for stability and compared against the core's current interrupt priority threshold and its trap-enable flag. The highest code cannot be masked.

When the block accepts a request, it enters a trap. It records the address of the interrupted instruction and the address of the instruction after it. It raises a one-cycle pipeline flush and forces the core into supervisor mode, keeping the previous mode so it can be restored later. It also disables further maskable traps. The handler address is built from a trap base register and a trap type derived from the level.

A return request reverses the entry: it restores the saved mode, re-enables traps and presents the saved addresses so that the fetch logic can redirect. A status write port lets the core load the enable and supervisor flags directly.

Top module: `irq_trap_unit`

## Requirements
- R1: The request code passes through two synchronising flops and is acted on only after two consecutive synchronised samples agree. A code held from before clock edge E0 can produce a flush at the earliest in the cycle after edge E3. A code present for a single cycle never produces a trap.
- R2: A request code of 0 never produces a trap.
- R3: Code 15 produces a trap whatever the threshold and the enable flag are.
- R4: A code from 1 to 14 produces a trap only when the enable flag is 1 and the code is strictly greater than the 4-bit threshold `pil_i`.
- R5: On trap entry, `epc_o` holds the value of `cur_pc_i` and `enpc_o` holds the value of `next_pc_i`, both sampled at the entry edge.
- R6: `flush_o` is high for exactly one cycle per trap entry. No trap is taken in that flush cycle.
- R7: On trap entry, `super_o` becomes 1 and `et_o` becomes 0. The previous supervisor value is kept for the return.
- R8: `handler_o` equals {`tbr_base_i`, 8-bit trap type 0x10 + code, 4'b0000}, latched at trap entry.
- R9: A maskable request that is blocked because the enable flag is 0 stays pending. It is taken one edge after the flag is set, provided the code is still present.
- R10: `rett_i`, in a cycle with no trap entry, restores the saved supervisor value and sets the enable flag to 1. It also raises `ret_o` for one cycle, with `epc_o` and `enpc_o` still holding the saved addresses.
- R11: After reset, `flush_o`=0, `ret_o`=0, `et_o`=0, `super_o`=1 and `epc_o`=`enpc_o`=0. `st_wr_i` loads `et_o` and `super_o` from `st_et_i` and `st_super_i`, with lower priority than trap entry and return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl_i | input | 4 | Encoded external interrupt level, 0 = none |
| pil_i | input | 4 | Processor interrupt priority threshold |
| cur_pc_i | input | ADDR_W | Address of the current instruction |
| next_pc_i | input | ADDR_W | Address of the next instruction |
| tbr_base_i | input | ADDR_W-12 | Upper bits of the trap base register |
| rett_i | input | 1 | Return-from-trap request |
| st_wr_i | input | 1 | Status write strobe |
| st_et_i | input | 1 | Enable value to write |
| st_super_i | input | 1 | Supervisor value to write |
| flush_o | output | 1 | One-cycle pipeline flush on trap entry |
| handler_o | output | ADDR_W | Handler address |
| epc_o | output | ADDR_W | Saved current address |
| enpc_o | output | ADDR_W | Saved next address |
| ret_o | output | 1 | One-cycle return redirect pulse |
| super_o | output | 1 | Supervisor mode |
| et_o | output | 1 | Trap enable flag |

## Verification
A corrupted synchroniser or stability register shows up as a flush one cycle early or late relative to the held code. It can also show up as a trap caused by a one-cycle glitch, visible within four edges of the stimulus. Wrong mask state is exposed by sweeping every code against every threshold with the enable flag at both values, which leaves a missing or extra flush right at the expected edge. A wrong saved mode or address shows up on `super_o`, `et_o`, `epc_o` and `enpc_o` in the cycle after entry or after the return.

// File: rtl/irq_trap_unit.sv
module irq_trap_unit #(
  parameter int          ADDR_W  = 32,
  parameter int          LVL_W   = 4,
  parameter logic [7:0]  TT_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [ADDR_W-13:0] tbr_base_i,
  input  logic              rett_i,
  input  logic              st_wr_i,
  input  logic              st_et_i,
  input  logic              st_super_i,
  output logic              flush_o,
  output logic [ADDR_W-1:0] handler_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] enpc_o,
  output logic              ret_o,
  output logic              super_o,
  output logic              et_o
);

  localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

  logic [LVL_W-1:0] sync1_q, sync2_q, hist_q;
  logic [LVL_W-1:0] lvl_eff;
  logic             et_q, super_q, prev_super_q, flush_q, ret_q;
  logic [ADDR_W-1:0] epc_q, enpc_q, hdl_q;
  logic             take, do_ret;
  logic [7:0]       tt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      hist_q  <= '0;
    end else begin
      sync1_q <= irq_lvl_i;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end

  assign lvl_eff = (sync2_q == hist_q) ? sync2_q : '0;

  assign take = (lvl_eff != '0) && !flush_q &&
                ((lvl_eff == NMI_LVL) || (et_q && (lvl_eff > pil_i)));
  assign do_ret = rett_i && !take;
  assign tt = TT_BASE + 8'(lvl_eff);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      et_q         <= 1'b0;
      super_q      <= 1'b1;
      prev_super_q <= 1'b1;
      flush_q      <= 1'b0;
      ret_q        <= 1'b0;
      epc_q        <= '0;
      enpc_q       <= '0;
      hdl_q        <= '0;
    end else begin
      flush_q <= take;
      ret_q   <= do_ret;
      if (take) begin
        epc_q        <= cur_pc_i;
        enpc_q       <= next_pc_i;
        hdl_q        <= {tbr_base_i, tt, 4'h0};
        prev_super_q <= super_q;
        super_q      <= 1'b1;
        et_q         <= 1'b0;
      end else if (do_ret) begin
        super_q <= prev_super_q;
        et_q    <= 1'b1;
      end else if (st_wr_i) begin
        super_q <= st_super_i;
        et_q    <= st_et_i;
      end
    end

  assign flush_o   = flush_q;
  assign ret_o     = ret_q;
  assign handler_o = hdl_q;
  assign epc_o     = epc_q;
  assign enpc_o    = enpc_q;
  assign super_o   = super_q;
  assign et_o      = et_q;

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q); // R6
  AST_NMI_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2_q == NMI_LVL && hist_q == NMI_LVL && !flush_q) |=> flush_q); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!et_q && !(sync2_q == NMI_LVL && hist_q == NMI_LVL)) |=> !flush_q); // R4
  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (super_q && !et_q)); // R7
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_q) |-> (epc_q == $past(cur_pc_i) && enpc_q == $past(next_pc_i))); // R5
  AST_RET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q |-> et_q); // R10
  AST_GLITCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2_q != hist_q) |=> !flush_q); // R1

endmodule

// File: tb/irq_trap_unit_test.sv
module irq_trap_unit_test;
  localparam int AW = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [3:0]    irq_lvl_i = 0, pil_i = 0;
  logic [AW-1:0] cur_pc_i = 0, next_pc_i = 0;
  logic [AW-13:0] tbr_base_i = 20'hABCDE;
  logic          rett_i = 0, st_wr_i = 0, st_et_i = 0, st_super_i = 0;
  logic          flush_o, ret_o, super_o, et_o;
  logic [AW-1:0] handler_o, epc_o, enpc_o;

  int total = 0, bad = 0;
  bit done = 0;

  irq_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .pil_i(pil_i),
    .cur_pc_i(cur_pc_i), .next_pc_i(next_pc_i), .tbr_base_i(tbr_base_i),
    .rett_i(rett_i), .st_wr_i(st_wr_i), .st_et_i(st_et_i), .st_super_i(st_super_i),
    .flush_o(flush_o), .handler_o(handler_o), .epc_o(epc_o), .enpc_o(enpc_o),
    .ret_o(ret_o), .super_o(super_o), .et_o(et_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk("R11 flush", flush_o, 0);
    chk("R11 ret", ret_o, 0);
    chk("R11 et", et_o, 0);
    chk("R11 super", super_o, 1);
    chk("R11 epc", epc_o, 0);
    chk("R11 enpc", enpc_o, 0);
    rst_n = 1;
    idle(2);

    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 16; p++)
        for (int l = 0; l < 16; l++) begin
          logic exp_take;
          exp_take = (l == 15) || (l != 0 && e == 1 && l > p);
          st_wr_i = 1; st_et_i = e[0]; st_super_i = 0;
          irq_lvl_i = l[3:0]; pil_i = p[3:0];
          cur_pc_i = 32'h4000_0000 + 32'((e * 256 + p * 16 + l) * 8);
          next_pc_i = cur_pc_i + 4;
          @(negedge clk);
          st_wr_i = 0;
          chk("R11 write et", et_o, e[0]);
          chk("R11 write super", super_o, 0);
          idle(2);
          chk("R1 not early", flush_o, 0);
          @(negedge clk);
          if (l == 0) chk("R2 idle", flush_o, 0);
          else if (l == 15) chk("R3 nmi", flush_o, 1);
          else chk("R4 mask", flush_o, exp_take);
          if (exp_take) begin
            chk("R5 epc", epc_o, cur_pc_i);
            chk("R5 enpc", enpc_o, next_pc_i);
            chk("R7 super", super_o, 1);
            chk("R7 et", et_o, 0);
            chk("R8 handler", handler_o, {tbr_base_i, 8'h10 + 8'(l), 4'h0});
          end
          irq_lvl_i = 0;
          @(negedge clk);
          chk("R6 one cycle", flush_o, 0);
          idle(4);
        end

    st_wr_i = 1; st_et_i = 1; st_super_i = 0; pil_i = 0;
    @(negedge clk);
    st_wr_i = 0;
    irq_lvl_i = 5;
    @(negedge clk);
    irq_lvl_i = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 glitch", flush_o, 0);
    end

    st_wr_i = 1; st_et_i = 0; st_super_i = 0; pil_i = 2;
    irq_lvl_i = 7; cur_pc_i = 32'h0000_8000; next_pc_i = 32'h0000_8004;
    @(negedge clk);
    st_wr_i = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 held", flush_o, 0);
    end
    st_wr_i = 1; st_et_i = 1; st_super_i = 0;
    @(negedge clk);
    st_wr_i = 0;
    chk("R9 not yet", flush_o, 0);
    @(negedge clk);
    chk("R9 taken", flush_o, 1);
    chk("R8 handler 7", handler_o, {tbr_base_i, 8'h17, 4'h0});
    irq_lvl_i = 0;
    cur_pc_i = 0; next_pc_i = 0;
    idle(5);
    chk("R7 masked after", et_o, 0);

    rett_i = 1;
    @(negedge clk);
    rett_i = 0;
    chk("R10 ret pulse", ret_o, 1);
    chk("R10 super restored", super_o, 0);
    chk("R10 et set", et_o, 1);
    chk("R10 epc", epc_o, 32'h0000_8000);
    chk("R10 enpc", enpc_o, 32'h0000_8004);
    @(negedge clk);
    chk("R10 pulse ends", ret_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule